// File: doc/BRIEF.md
# Constant volts-per-hertz sine reference generator

This block turns one unsigned speed command into a pair of sinusoidal references for a modulator that compares them against carriers. The first reference is a sine. The second is the same sine advanced by half a period, which makes it the inverted waveform. One speed word sets both the amplitude and the frequency of the pair, so the ratio between them stays fixed as the command moves.

The amplitude path multiplies the command by a fixed-point gain of 1707/1024 (about 1.667), so a command of 1500 yields 2500. The frequency path has three parts. A free-running prescale counter issues one-cycle ticks. Each tick adds the command to a phase accumulator, and the upper bits of that accumulator address a computed sine table. Each table value is scaled by the amplitude and registered.

A new command takes effect only when the accumulator wraps, or at once if the speed in use is zero. A running waveform therefore never changes step in the middle of a period.

Top module: `vf_sine_ref`

## Requirements
- R1: While reset is high, `amp_word`, `ref_sin` and `ref_inv` are all zero, and the speed in use and the accumulator are cleared.
- R2: `amp_word` equals floor(S*1707/1024), where S is the speed in use; with S = 1500 it reads 2500.
- R3: A prescale counter issues a one-cycle tick every PRESCALE+1 clocks. On each tick the 16-bit accumulator adds S modulo 2^16, and it holds its value on every other clock.
- R4: The table phase is the accumulator shifted right by 8 bits (0..255). Table entry p for p < 128 is floor(131056*q/(81920-4q)) with q = p*(128-p). For p >= 128 the entry is the negative of entry p-128. The peak is 8191.
- R5: One clock after a phase is presented, `ref_sin` equals floor(entry(phase)*A/8192), where A is the amplitude word of that cycle. Floor is taken toward minus infinity.
- R6: `ref_inv` follows the rule of R5 using the table entry at (phase+128) mod 256.
- R7: The speed command is copied into the speed in use only in a cycle where a tick carries the accumulator out of its 16 bits, or in a cycle where the speed in use is zero. At all other times a change of the command has no effect on `amp_word`.
- R8: While the speed in use is zero, the accumulator does not move, and `amp_word`, `ref_sin` and `ref_inv` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_cmd | input | 12 | Unsigned speed command |
| amp_word | output | 16 | Amplitude derived from the speed in use |
| ref_sin | output | 16 | Signed sine reference sample |
| ref_inv | output | 16 | Signed half-period-shifted (inverted) reference sample |

## Verification
The tick-spacing property assumes PRESCALE is at least 1, so two ticks are never adjacent. The bench builds the block with PRESCALE = 3. The properties also assume the command fits in 12 bits, which keeps the amplitude and the scaled product inside 16 bits. The stimulus stays within both limits.

The bench changes the command only on the falling clock edge. It makes the mid-period change at a point where its own model shows that no wrap can occur within the next few ticks.

// File: rtl/vf_pkg.sv
package vf_pkg;

  // Fixed-point amplitude: floor(spd * gain / 2^frac)
  function automatic int amp_of(input int spd, input int gain, input int frac);
    longint prod;
    prod = longint'(spd) * longint'(gain);
    return int'(prod >>> frac);
  endfunction

  // Rational sine approximation over one period of 2^ph_w steps
  function automatic int sine_entry(input int p, input int ph_w, input int peak);
    longint half;
    longint pp;
    longint q;
    longint v;
    half = longint'(1) << (ph_w - 1);
    pp   = longint'(p) % half;
    q    = pp * (half - pp);
    v    = (16 * longint'(peak) * q) / (5 * half * half - 4 * q);
    if (longint'(p) >= half) v = -v;
    return int'(v);
  endfunction

  // Scale a signed table value by the amplitude, floor toward -inf
  function automatic int scale_ref(input int s, input int amp, input int tbl_w);
    longint prod;
    prod = longint'(s) * longint'(amp);
    return int'(prod >>> (tbl_w - 1));
  endfunction

endpackage

// File: rtl/vf_tick_gen.sv
module vf_tick_gen #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 49
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(PRESCALE));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

endmodule

// File: rtl/vf_phase_acc.sv
module vf_phase_acc #(
  parameter int SPEED_W = 12,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [SPEED_W-1:0] speed_cmd,
  output logic [ACC_W-1:0]   acc,
  output logic [SPEED_W-1:0] speed_live,
  output logic               wrap
);

  logic [ACC_W:0] sum;
  logic           load_ok;

  assign sum     = {1'b0, acc} + (ACC_W+1)'(speed_live);
  assign wrap    = tick & sum[ACC_W];
  assign load_ok = wrap | (speed_live == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      speed_live <= '0;
    end else begin
      if (tick)    acc        <= sum[ACC_W-1:0];
      if (load_ok) speed_live <= speed_cmd;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(acc));

  // R7
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrap || speed_live == '0) |=> $stable(speed_live));

  // R8
  zero_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (speed_live == '0) |=> $stable(acc));

endmodule

// File: rtl/vf_ref_stage.sv
module vf_ref_stage
  import vf_pkg::*;
#(
  parameter int PH_W  = 8,
  parameter int TBL_W = 14,
  parameter int AMP_W = 16,
  parameter int REF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         phase,
  input  logic [AMP_W-1:0]        amp,
  output logic signed [REF_W-1:0] ref_sin,
  output logic signed [REF_W-1:0] ref_inv
);

  localparam int PH_N = 1 << PH_W;
  localparam int PEAK = (1 << (TBL_W - 1)) - 1;

  logic signed [TBL_W-1:0] tbl [PH_N];
  logic [PH_W-1:0]         phase_inv;

  for (genvar i = 0; i < PH_N; i++) begin : g_tbl
    assign tbl[i] = TBL_W'(sine_entry(i, PH_W, PEAK));
  end

  assign phase_inv = phase + PH_W'(PH_N / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sin <= '0;
      ref_inv <= '0;
    end else begin
      ref_sin <= REF_W'(scale_ref(int'(tbl[phase]), int'(amp), TBL_W));
      ref_inv <= REF_W'(scale_ref(int'(tbl[phase_inv]), int'(amp), TBL_W));
    end
  end

  // R5
  zero_amp_chk: assert property (@(posedge clk) disable iff (rst)
    (amp == '0) |=> (ref_sin == '0 && ref_inv == '0));

endmodule

// File: rtl/vf_sine_ref.sv
module vf_sine_ref
  import vf_pkg::*;
#(
  parameter int SPEED_W   = 12,
  parameter int CNT_W     = 16,
  parameter int PRESCALE  = 49,
  parameter int ACC_W     = 16,
  parameter int PH_SHIFT  = 8,
  parameter int TBL_W     = 14,
  parameter int GAIN_Q    = 1707,
  parameter int GAIN_FRAC = 10,
  parameter int AMP_W     = 16,
  parameter int REF_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SPEED_W-1:0]      speed_cmd,
  output logic [AMP_W-1:0]        amp_word,
  output logic signed [REF_W-1:0] ref_sin,
  output logic signed [REF_W-1:0] ref_inv
);

  localparam int PH_W = ACC_W - PH_SHIFT;

  logic               tick;
  logic               wrap;
  logic [ACC_W-1:0]   acc;
  logic [SPEED_W-1:0] speed_live;
  logic [PH_W-1:0]    phase;

  vf_tick_gen #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  vf_phase_acc #(.SPEED_W(SPEED_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .speed_cmd(speed_cmd),
    .acc(acc), .speed_live(speed_live), .wrap(wrap)
  );

  assign phase    = acc[ACC_W-1:PH_SHIFT];
  assign amp_word = AMP_W'(amp_of(int'(speed_live), GAIN_Q, GAIN_FRAC));

  vf_ref_stage #(.PH_W(PH_W), .TBL_W(TBL_W), .AMP_W(AMP_W), .REF_W(REF_W)) u_ref (
    .clk(clk), .rst(rst), .phase(phase), .amp(amp_word),
    .ref_sin(ref_sin), .ref_inv(ref_inv)
  );

  // R2
  amp_track_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(speed_live) |-> $stable(amp_word));

  // R7
  wrap_tick_chk: assert property (@(posedge clk) disable iff (rst) wrap |-> tick);

endmodule

// File: tb/sim_vf_sine_ref.sv
module sim_vf_sine_ref;

  localparam int PERIOD = 20;
  localparam int PRE    = 3;

  typedef struct { int ra; int rb; int am; } exp_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [11:0]         speed = '0;
  logic [15:0]         amp_word;
  logic signed [15:0]  ref_sin;
  logic signed [15:0]  ref_inv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  exp_t sb_q[$];

  int m_cnt, m_acc, m_live;

  always #(PERIOD/2) clk = ~clk;

  vf_sine_ref #(.PRESCALE(PRE)) u0 (
    .clk(clk), .rst(rst), .speed_cmd(speed),
    .amp_word(amp_word), .ref_sin(ref_sin), .ref_inv(ref_inv)
  );

  function automatic int tbl_ref(input int p);
    longint x, q, v;
    x = longint'(p & 127);
    q = x * (128 - x);
    v = (longint'(131056) * q) / (longint'(81920) - 4 * q);
    return (p >= 128) ? -int'(v) : int'(v);
  endfunction

  function automatic int amp_ref(input int s);
    return (s * 1707) / 1024;
  endfunction

  function automatic int out_ref(input int p, input int a);
    longint pr;
    pr = longint'(tbl_ref(p)) * longint'(a);
    return int'(pr >>> 13);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model (driver side): predicts outputs after each edge
  always @(posedge clk) begin
    int a_old, ph, ea, eb, s;
    bit t, w;
    exp_t e;
    if (rst) begin
      m_cnt = 0; m_acc = 0; m_live = 0;
    end else begin
      a_old = amp_ref(m_live);
      ph    = (m_acc >> 8) & 255;
      ea    = out_ref(ph, a_old);
      eb    = out_ref((ph + 128) & 255, a_old);
      t     = (m_cnt == PRE);
      w     = 1'b0;
      if (t) begin
        s = m_acc + m_live;
        w = (s > 65535);
        m_acc = s & 65535;
      end
      m_cnt = t ? 0 : m_cnt + 1;
      if (w || m_live == 0) m_live = int'(speed);
      e.ra = ea; e.rb = eb; e.am = amp_ref(m_live);
      sb_q.push_back(e);
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk("R2 amp_word", int'(amp_word), e.am);
      chk("R4/R5 ref_sin", int'(ref_sin), e.ra);
      chk("R6 ref_inv", int'(ref_inv), e.rb);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 amp_word", int'(amp_word), 0);
    chk("R1 ref_sin", int'(ref_sin), 0);
    chk("R1 ref_inv", int'(ref_inv), 0);
    rst = 1'b0;
    // R8 zero command: everything stays at zero
    cyc(40);
    chk("R8 amp_word", int'(amp_word), 0);
    chk("R8 ref_sin", int'(ref_sin), 0);
    // R2 nominal command
    speed = 12'd1500;
    cyc(3);
    chk("R2 amp at 1500", int'(amp_word), 2500);
    cyc(600);
    // R7 change away from a wrap: no effect until the next wrap
    do @(negedge clk); while (!(m_cnt == 0 && m_acc > 8000 && m_acc + 3 * 1500 < 65536));
    speed = 12'd600;
    cyc(2);
    chk("R7 amp held", int'(amp_word), 2500);
    cyc(1200);
    chk("R7 amp after wrap", int'(amp_word), amp_ref(600));
    // R3 fast sweep at full scale
    speed = 12'd4095;
    cyc(900);
    // R8 drop to zero; takes effect at wrap, then frozen
    speed = 12'd0;
    cyc(1500);
    chk("R8 amp zero", int'(amp_word), 0);
    chk("R8 ref_sin zero", int'(ref_sin), 0);
    chk("R8 ref_inv zero", int'(ref_inv), 0);
    // R8 restart: phase resumes from the frozen accumulator
    speed = 12'd300;
    cyc(800);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule